// File: doc/BRIEF.md
# Single-Level Page Address Translator

This block turns a 16-bit virtual address into a physical address through a 16-entry page table that it holds itself. The upper four address bits select a table entry and the lower twelve bits, the position inside a 4096-byte page, pass straight through. Each entry has the following fields:

- a physical frame number;
- a present flag;
- a writable flag;
- a referenced flag;
- a modified flag.

Software loads a whole entry in one cycle through a table write port. A combinational read port shows any entry's current contents.

The block takes an access request (an address plus a write flag) in any cycle and answers on the next cycle. The answer is either the physical address or a fault code. The present flag is checked first. A write to an entry whose writable flag is clear is then refused. A successful access sets the entry's referenced flag. A successful write also sets its modified flag. Nothing outside the table is modelled: there is no replacement policy, no swapping and no multi-level walk.

Top module: `page_xlator`

## Requirements
- R1: After reset, rspValid is 0 and every entry shows present, writable, referenced and modified as 0 and frame as 0 on the read port.
- R2: For a request whose entry is present and whose access is allowed, the response carries fault code 00 and the address {frame, offset}, where the entry index is reqAddr[15:12] and the offset is reqAddr[11:0]. For example, with entry 2 mapped to frame 6, address 0x2004 gives 0x6004.
- R3: A request to an entry whose present flag is 0 answers with fault code 01 and address 0, and leaves the entry's referenced and modified flags unchanged.
- R4: A write request to a present entry whose writable flag is 0 answers with fault code 10 and address 0, and changes no flag. A read of that entry succeeds.
- R5: A successful read sets the entry's referenced flag and leaves its modified flag unchanged. A successful write sets both flags.
- R6: A table write loads frame, present, writable, referenced and modified for the chosen entry in one cycle. The new values show on the read port from the following cycle.
- R7: If a table write and an access hit the same entry in one cycle, the entry ends with exactly the written values. The access itself is judged on the entry's contents from before that edge.
- R8: rspValid is 1 exactly in the cycle after a cycle with reqValid 1, and 0 otherwise. While rspValid is 0, rspAddr and rspFault are 0.
- R9: An absent entry reports fault 01 even for a write to an entry that is also not writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Load one table entry |
| tblWrIdx | input | 4 | Entry to load |
| tblWrFrame | input | FRAME_W (4) | Frame number to load |
| tblWrPresent | input | 1 | Present flag to load |
| tblWrWritable | input | 1 | Writable flag to load |
| tblWrRef | input | 1 | Referenced flag to load |
| tblWrMod | input | 1 | Modified flag to load |
| tblRdIdx | input | 4 | Entry shown on the read port |
| tblRdFrame | output | FRAME_W (4) | Frame of the shown entry |
| tblRdPresent | output | 1 | Present flag of the shown entry |
| tblRdWritable | output | 1 | Writable flag of the shown entry |
| tblRdRef | output | 1 | Referenced flag of the shown entry |
| tblRdMod | output | 1 | Modified flag of the shown entry |
| reqValid | input | 1 | Access request this cycle |
| reqAddr | input | 16 | Virtual address |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| rspValid | output | 1 | Response valid |
| rspAddr | output | FRAME_W+12 (16) | Physical address, 0 on a fault |
| rspFault | output | 2 | 00 none, 01 not present, 10 write protection |

## Verification
In a single cycle, a table load and a hardware update of the referenced and modified flags can target the same entry. The bench provokes this by pairing a request with a table write to the same index, both on purpose and at random. It expects the written values to remain on the read port afterwards. It also expects the response in that cycle to reflect the entry as it stood before the write.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_WPROT  = 2'b10
  } faultCode_t;

  typedef struct packed {
    logic       accept;
    logic       hit;
    logic       setRef;
    logic       setMod;
    faultCode_t fault;
  } ctrlStrobe_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        selPresent,
  input  logic        selWritable,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    strobe.accept = reqValid;
    if (reqValid) begin
      if (!selPresent) begin
        strobe.fault = FLT_ABSENT;
      end else if (reqWrite && !selWritable) begin
        strobe.fault = FLT_WPROT;
      end else begin
        strobe.hit    = 1'b1;
        strobe.setRef = 1'b1;
        strobe.setMod = reqWrite;
      end
    end
  end

  // R4: a refused write never marks the page modified
  a_r4_no_mod_on_wprot: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && selPresent && !selWritable) |-> !strobe.setMod && !strobe.hit);

  // R9: absence outranks protection
  a_r9_absent_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !selPresent) |-> (strobe.fault == FLT_ABSENT));

endmodule

// File: rtl/xlat_path.sv
module xlat_path
  import xlat_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int ENTRIES  = 1 << VPN_W,
  localparam int PA_W     = FRAME_W + PAGE_BITS
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic [VPN_W-1:0]   tblWrIdx,
  input  logic [FRAME_W-1:0] tblWrFrame,
  input  logic               tblWrPresent,
  input  logic               tblWrWritable,
  input  logic               tblWrRef,
  input  logic               tblWrMod,
  input  logic [VPN_W-1:0]   tblRdIdx,
  output logic [FRAME_W-1:0] tblRdFrame,
  output logic               tblRdPresent,
  output logic               tblRdWritable,
  output logic               tblRdRef,
  output logic               tblRdMod,
  input  logic [VA_W-1:0]    reqAddr,
  output logic               selPresent,
  output logic               selWritable,
  input  ctrlStrobe_t        strobe,
  output logic               rspValid,
  output logic [PA_W-1:0]    rspAddr,
  output logic [1:0]         rspFault
);

  logic [FRAME_W-1:0] frameTbl [ENTRIES];
  logic [ENTRIES-1:0] presTbl, wrblTbl, refTbl, modTbl;
  logic [FRAME_W-1:0] frameNxt [ENTRIES];
  logic [ENTRIES-1:0] presNxt, wrblNxt, refNxt, modNxt;

  logic [VPN_W-1:0]     reqVpn;
  logic [PAGE_BITS-1:0] reqOff;
  assign reqVpn = reqAddr[VA_W-1:PAGE_BITS];
  assign reqOff = reqAddr[PAGE_BITS-1:0];

  assign selPresent  = presTbl[reqVpn];
  assign selWritable = wrblTbl[reqVpn];

  assign tblRdFrame    = frameTbl[tblRdIdx];
  assign tblRdPresent  = presTbl[tblRdIdx];
  assign tblRdWritable = wrblTbl[tblRdIdx];
  assign tblRdRef      = refTbl[tblRdIdx];
  assign tblRdMod      = modTbl[tblRdIdx];

  // per-entry next state: table write overrides a hardware flag update
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic loadHere, touchHere;
    assign loadHere  = tblWrEn && (tblWrIdx == VPN_W'(e));
    assign touchHere = strobe.hit && (reqVpn == VPN_W'(e));
    assign frameNxt[e] = loadHere ? tblWrFrame    : frameTbl[e];
    assign presNxt[e]  = loadHere ? tblWrPresent  : presTbl[e];
    assign wrblNxt[e]  = loadHere ? tblWrWritable : wrblTbl[e];
    assign refNxt[e]   = loadHere ? tblWrRef : (refTbl[e] | (touchHere & strobe.setRef));
    assign modNxt[e]   = loadHere ? tblWrMod : (modTbl[e] | (touchHere & strobe.setMod));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) frameTbl[i] <= '0;
      presTbl <= '0;
      wrblTbl <= '0;
      refTbl  <= '0;
      modTbl  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) frameTbl[i] <= frameNxt[i];
      presTbl <= presNxt;
      wrblTbl <= wrblNxt;
      refTbl  <= refNxt;
      modTbl  <= modNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspFault <= '0;
    end else begin
      rspValid <= strobe.accept;
      rspFault <= strobe.fault;
      rspAddr  <= strobe.hit ? {frameTbl[reqVpn], reqOff} : '0;
    end
  end

  // R3: a faulting response never carries an address
  a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> (rspAddr == '0));

  // R7: a table load leaves exactly the written flags
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn |=> (refTbl[$past(tblWrIdx)] == $past(tblWrRef)) &&
                (modTbl[$past(tblWrIdx)] == $past(tblWrMod)));

  // R5: modified is only ever set by a write hit or a load
  a_r5_mod_source: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMod) |-> strobe.setRef);

endmodule

// File: rtl/page_xlator.sv
module page_xlator
  import xlat_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = FRAME_W + PAGE_BITS
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic [VPN_W-1:0]   tblWrIdx,
  input  logic [FRAME_W-1:0] tblWrFrame,
  input  logic               tblWrPresent,
  input  logic               tblWrWritable,
  input  logic               tblWrRef,
  input  logic               tblWrMod,
  input  logic [VPN_W-1:0]   tblRdIdx,
  output logic [FRAME_W-1:0] tblRdFrame,
  output logic               tblRdPresent,
  output logic               tblRdWritable,
  output logic               tblRdRef,
  output logic               tblRdMod,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqAddr,
  input  logic               reqWrite,
  output logic               rspValid,
  output logic [PA_W-1:0]    rspAddr,
  output logic [1:0]         rspFault
);

  ctrlStrobe_t strobe;
  logic        selPresent, selWritable;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .selPresent (selPresent),
    .selWritable(selWritable),
    .strobe     (strobe)
  );

  xlat_path #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .tblWrEn      (tblWrEn),
    .tblWrIdx     (tblWrIdx),
    .tblWrFrame   (tblWrFrame),
    .tblWrPresent (tblWrPresent),
    .tblWrWritable(tblWrWritable),
    .tblWrRef     (tblWrRef),
    .tblWrMod     (tblWrMod),
    .tblRdIdx     (tblRdIdx),
    .tblRdFrame   (tblRdFrame),
    .tblRdPresent (tblRdPresent),
    .tblRdWritable(tblRdWritable),
    .tblRdRef     (tblRdRef),
    .tblRdMod     (tblRdMod),
    .reqAddr      (reqAddr),
    .selPresent   (selPresent),
    .selWritable  (selWritable),
    .strobe       (strobe),
    .rspValid     (rspValid),
    .rspAddr      (rspAddr),
    .rspFault     (rspFault)
  );

  // R8: one response per request, one cycle later
  a_r8_rsp_timing: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && rspFault == 2'b00 && rspAddr == '0);

  // R2: offset passes through on a hit
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspFault != 2'b00) || (rspAddr[PAGE_BITS-1:0] == $past(reqAddr[PAGE_BITS-1:0])));

endmodule

// File: tb/page_xlator_tb.sv
module page_xlator_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tblWrEn, tblWrPresent, tblWrWritable, tblWrRef, tblWrMod;
  logic [3:0]  tblWrIdx, tblWrFrame, tblRdIdx;
  logic [3:0]  tblRdFrame;
  logic        tblRdPresent, tblRdWritable, tblRdRef, tblRdMod;
  logic        reqValid, reqWrite;
  logic [15:0] reqAddr;
  logic        rspValid;
  logic [15:0] rspAddr;
  logic [1:0]  rspFault;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [3:0] mFrame [16];
  logic       mPres [16], mWrbl [16], mRef [16], mMod [16];

  always #5 clk = ~clk;

  page_xlator u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    tblWrEn = 0; tblWrIdx = 0; tblWrFrame = 0; tblWrPresent = 0;
    tblWrWritable = 0; tblWrRef = 0; tblWrMod = 0;
    reqValid = 0; reqAddr = 0; reqWrite = 0;
  endtask

  function automatic logic [31:0] packEntry(input logic [3:0] f, input logic p, input logic w,
                                            input logic r, input logic m);
    return {24'd0, f, p, w, r, m};
  endfunction

  // check one table entry on the read port against the model
  task automatic checkEntry(input int idx, input string req);
    tblRdIdx = 4'(idx);
    #1;
    chk(packEntry(tblRdFrame, tblRdPresent, tblRdWritable, tblRdRef, tblRdMod) ==
        packEntry(mFrame[idx], mPres[idx], mWrbl[idx], mRef[idx], mMod[idx]), req,
        packEntry(tblRdFrame, tblRdPresent, tblRdWritable, tblRdRef, tblRdMod),
        packEntry(mFrame[idx], mPres[idx], mWrbl[idx], mRef[idx], mMod[idx]));
  endtask

  // one cycle: optional table write, optional request; checks response (R2,R3,R4,R8,R9)
  task automatic cycle(input bit doWr, input logic [3:0] wIdx, input logic [3:0] wFr,
                       input logic wP, input logic wW, input logic wR, input logic wM,
                       input bit doReq, input logic [15:0] addr, input logic isWr, input string req);
    logic [3:0] vpn;
    logic       expValid;
    logic [1:0] expFault;
    logic [15:0] expAddr;
    vpn = addr[15:12];
    tblWrEn = doWr; tblWrIdx = wIdx; tblWrFrame = wFr; tblWrPresent = wP;
    tblWrWritable = wW; tblWrRef = wR; tblWrMod = wM;
    reqValid = doReq; reqAddr = addr; reqWrite = isWr;
    expValid = doReq;
    expFault = 2'b00;
    expAddr  = 16'h0;
    if (doReq) begin
      if (!mPres[vpn]) expFault = 2'b01;
      else if (isWr && !mWrbl[vpn]) expFault = 2'b10;
      else begin
        expAddr = {mFrame[vpn], addr[11:0]};
        mRef[vpn] = 1'b1;
        if (isWr) mMod[vpn] = 1'b1;
      end
    end
    if (doWr) begin
      mFrame[wIdx] = wFr; mPres[wIdx] = wP; mWrbl[wIdx] = wW; mRef[wIdx] = wR; mMod[wIdx] = wM;
    end
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    chk({rspValid, rspFault, rspAddr} == {expValid, expFault, expAddr}, req,
        {13'd0, rspValid, rspFault, rspAddr}, {13'd0, expValid, expFault, expAddr});
  endtask

  task automatic load(input logic [3:0] idx, input logic [3:0] fr, input logic p, input logic w);
    cycle(1, idx, fr, p, w, 0, 0, 0, 16'h0, 0, "R6 load");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idleInputs();
    tblRdIdx = 0;
    rstN = 0;
    for (int i = 0; i < 16; i++) begin
      mFrame[i] = 0; mPres[i] = 0; mWrbl[i] = 0; mRef[i] = 0; mMod[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(rspValid == 1'b0, "R1 rspValid", rspValid, 0);
    for (int i = 0; i < 16; i++) checkEntry(i, "R1 entry cleared");

    // R3 absent entry, read and write
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h5123, 0, "R3 absent read");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h5123, 1, "R9 absent write");
    checkEntry(5, "R3 flags untouched");

    // R2 worked example
    load(4'd2, 4'd6, 1, 1);
    checkEntry(2, "R6 loaded entry");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h2004, 0, "R2 0x2004->0x6004");
    chk(16'h6004 == {mFrame[2], 12'h004}, "R2 example model", {mFrame[2], 12'h004}, 32'h6004);
    checkEntry(2, "R5 read sets ref only");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h2ffc, 1, "R2 write hit");
    checkEntry(2, "R5 write sets mod");

    // R4 read-only page
    load(4'd7, 4'd3, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h7010, 1, "R4 write refused");
    checkEntry(7, "R4 no flag change");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h7010, 0, "R4 read allowed");
    checkEntry(7, "R5 ref after read");

    // R9 absent and read-only
    load(4'd9, 4'd1, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 16'h9abc, 1, "R9 absent beats protection");

    // R7 same-cycle collision: write hit vs load clearing flags
    cycle(1, 4'd2, 4'd11, 1, 1, 0, 0, 1, 16'h2100, 1, "R7 rsp uses old entry");
    checkEntry(2, "R7 load wins");
    cycle(1, 4'd2, 4'd12, 1, 0, 1, 1, 1, 16'h2200, 1, "R7 rsp old writable");
    checkEntry(2, "R7 load wins 2");

    // R8 idle cycle
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 16'hffff, 1, "R8 no request no response");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] wi, fr;
      logic [15:0] a;
      bit dw, dq;
      dw = ($urandom % 3) == 0;
      dq = ($urandom % 4) != 0;
      wi = 4'($urandom);
      fr = 4'($urandom);
      a  = 16'($urandom);
      if (($urandom % 5) == 0) a[15:12] = wi;
      cycle(dw, wi, fr, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            dq, a, 1'($urandom), "R2/R3/R4/R7 random");
      if ((n % 8) == 0) checkEntry(int'(a[15:12]), "R5/R6 random entry");
    end
    for (int i = 0; i < 16; i++) checkEntry(i, "R6 final table");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule